// File: doc/BRIEF.md
# Power-On Jump Boot Controller

At power-up a processor starts fetching from a fixed address, while the boot code may live in some other region. This block makes the processor skip forward to that region. From reset onward it places a no-operation byte (all zeros) on the processor's data input and keeps the real data bus transceivers switched off. The processor executes these opcodes and its program counter advances. When the top bits of the address bus equal a 4-bit configuration value, such as a setting on a DIP switch, the block hands the data bus over to memory.

The raw equality result can glitch while address lines change state. For example, a change from 9 to A can briefly read as B. The block therefore never uses that result as a clock. It samples the result on the system clock together with an address-valid strobe. The result must match on two consecutive edges before a sticky handoff flag sets. Once set, the flag stays set until the next reset.

Top module: `boot_nop_gate`

## Requirements
- R1: While reset is asserted and on the first edge after it, force_en is 1, xcvr_en is 0 and force_data is 8'h00.
- R2: Whenever force_en is 1, force_data equals the no-operation byte 8'h00.
- R3: force_en and xcvr_en are always complementary. Both come from one register, so they change on the same clock edge.
- R4: A match means addr[15:12] equals cfg_region[3:0]. The value of addr[11:0] has no effect on the match.
- R5: A cycle in which addr_valid is 0 counts as no match, even if the address bits are equal.
- R6: If a matching, valid address is present at two consecutive rising edges, xcvr_en becomes 1 directly after the second edge (exactly two cycles of latency). It is still 0 after the first edge.
- R7: A matching value that lasts for only one sampled edge, with non-matching values on both sides, never causes handoff.
- R8: After handoff, xcvr_en stays 1 and force_en stays 0 whatever the address, addr_valid or cfg_region do.
- R9: Asserting reset after handoff returns the block to the forcing state of R1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 16 | Processor address bus |
| addr_valid | input | 1 | High when the address bus is stable and may be compared |
| cfg_region | input | 4 | Start region to wait for (compared with the top address bits) |
| force_data | output | 8 | Byte driven onto the processor data input while forcing |
| force_en | output | 1 | High while the forced byte drives the data input |
| xcvr_en | output | 1 | High once memory transceivers own the data bus |

## Verification
The bench injects a single-edge match between non-matching addresses, as in a 9-to-A change that reads as B. It also sends matches broken by a low addr_valid. A design that used one sample would hand off on these glitches and skip the start of the boot code. Latency is checked edge by edge, so an extra or missing confirmation stage shows up as handoff one cycle late or early. After handoff the bench drives non-matching addresses and a changed configuration. A flag that was not sticky would return the bus to forced NOPs.

// File: rtl/boot_nop_pkg.sv
package boot_nop_pkg;
   typedef enum logic {
      PH_FORCE   = 1'b0,
      PH_HANDOFF = 1'b1
   } boot_phase_e;

   localparam int unsigned DEF_ADDR_W  = 16;
   localparam int unsigned DEF_CMP_W   = 4;
   localparam int unsigned DEF_DATA_W  = 8;
   localparam int unsigned DEF_CONFIRM = 2;
endpackage

// File: rtl/bng_addr_cmp.sv
module bng_addr_cmp #(
   parameter int unsigned CMP_W = 4
) (
   input  logic [CMP_W-1:0] addr_hi,
   input  logic [CMP_W-1:0] region,
   input  logic             valid,
   output logic             hit
);
   logic [CMP_W-1:0] bit_eq;

   for (genvar i = 0; i < CMP_W; i++) begin : g_bit
      assign bit_eq[i] = ~(addr_hi[i] ^ region[i]);
   end

   // gate: compare counts only while the bus is declared stable
   assign hit = valid & (&bit_eq);
endmodule

// File: rtl/bng_confirm.sv
module bng_confirm #(
   parameter int unsigned CONFIRM = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic hit,
   output logic confirmed
);
   localparam int unsigned HIST_W = CONFIRM - 1;

   logic [HIST_W-1:0] hist;

   always_ff @(posedge clk) begin
      if (rst) hist[0] <= 1'b0;
      else     hist[0] <= hit;
   end

   for (genvar i = 1; i < HIST_W; i++) begin : g_stage
      always_ff @(posedge clk) begin
         if (rst) hist[i] <= 1'b0;
         else     hist[i] <= hist[i-1];
      end
   end

   // current sample plus CONFIRM-1 registered samples must all agree
   assign confirmed = hit & (&hist);
endmodule

// File: rtl/bng_flag.sv
module bng_flag
   import boot_nop_pkg::*;
(
   input  logic        clk,
   input  logic        rst,
   input  logic        set,
   output boot_phase_e phase
);
   always_ff @(posedge clk) begin
      if (rst)      phase <= PH_FORCE;
      else if (set) phase <= PH_HANDOFF;
   end
endmodule

// File: rtl/boot_nop_gate.sv
module boot_nop_gate
   import boot_nop_pkg::*;
#(
   parameter int unsigned     ADDR_W   = DEF_ADDR_W,
   parameter int unsigned     CMP_W    = DEF_CMP_W,
   parameter int unsigned     DATA_W   = DEF_DATA_W,
   parameter int unsigned     CONFIRM  = DEF_CONFIRM,
   parameter logic [DATA_W-1:0] NOP_BYTE = '0
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [ADDR_W-1:0] addr,
   input  logic              addr_valid,
   input  logic [CMP_W-1:0]  cfg_region,
   output logic [DATA_W-1:0] force_data,
   output logic              force_en,
   output logic              xcvr_en
);
   localparam int unsigned LOW_W = ADDR_W - CMP_W;

   if (CMP_W < 1 || CMP_W > ADDR_W) begin : g_bad_cmp
      $error("boot_nop_gate: CMP_W must be 1..ADDR_W");
   end
   if (CONFIRM < 2) begin : g_bad_confirm
      $error("boot_nop_gate: CONFIRM must be at least 2");
   end
   if (DATA_W < 1) begin : g_bad_data
      $error("boot_nop_gate: DATA_W must be positive");
   end

   if (LOW_W > 0) begin : g_low
      logic unused_low_bits;
      assign unused_low_bits = ^addr[LOW_W-1:0];
   end

   logic        hit;
   logic        confirmed;
   boot_phase_e phase;

   bng_addr_cmp #(.CMP_W(CMP_W)) u_cmp (
      .addr_hi (addr[ADDR_W-1 -: CMP_W]),
      .region  (cfg_region),
      .valid   (addr_valid),
      .hit     (hit)
   );

   bng_confirm #(.CONFIRM(CONFIRM)) u_confirm (
      .clk       (clk),
      .rst       (rst),
      .hit       (hit),
      .confirmed (confirmed)
   );

   bng_flag u_flag (
      .clk   (clk),
      .rst   (rst),
      .set   (confirmed),
      .phase (phase)
   );

   assign xcvr_en    = (phase == PH_HANDOFF);
   assign force_en   = (phase == PH_FORCE);
   assign force_data = force_en ? NOP_BYTE : '0;
endmodule

// File: rtl/boot_nop_gate_chk.sv
module boot_nop_gate_chk #(
   parameter int unsigned ADDR_W = 16,
   parameter int unsigned CMP_W  = 4,
   parameter int unsigned DATA_W = 8,
   parameter logic [DATA_W-1:0] NOP_BYTE = '0
) (
   input logic              clk,
   input logic              rst,
   input logic [ADDR_W-1:0] addr,
   input logic              addr_valid,
   input logic [CMP_W-1:0]  cfg_region,
   input logic [DATA_W-1:0] force_data,
   input logic              force_en,
   input logic              xcvr_en
);
   logic seen;
   assign seen = addr_valid && (addr[ADDR_W-1 -: CMP_W] == cfg_region);

   AST_RESET_STATE: assert property (@(posedge clk) rst |=> (force_en && !xcvr_en)); // R1
   AST_NOP_BYTE: assert property (@(posedge clk) disable iff (rst) force_en |-> (force_data == NOP_BYTE)); // R2
   AST_COMPLEMENT: assert property (@(posedge clk) disable iff (rst) force_en != xcvr_en); // R3
   AST_HANDOFF_LATENCY: assert property (@(posedge clk) disable iff (rst) (seen && $past(seen) && !$past(rst)) |=> xcvr_en); // R6
   AST_NO_GLITCH_HANDOFF: assert property (@(posedge clk) disable iff (rst) $rose(xcvr_en) |-> ($past(seen) && $past(seen, 2))); // R7
   AST_STICKY: assert property (@(posedge clk) disable iff (rst) xcvr_en |=> xcvr_en); // R8
endmodule

bind boot_nop_gate boot_nop_gate_chk #(
   .ADDR_W(ADDR_W), .CMP_W(CMP_W), .DATA_W(DATA_W), .NOP_BYTE(NOP_BYTE)
) u_chk (.*);

// File: tb/boot_nop_gate_tb.sv
module boot_nop_gate_tb;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [15:0] addr = 16'h0000;
   logic        addr_valid = 1'b0;
   logic [3:0]  cfg_region = 4'h0;
   logic [7:0]  force_data;
   logic        force_en;
   logic        xcvr_en;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #5 clk = ~clk;

   boot_nop_gate u_dut (
      .clk(clk), .rst(rst), .addr(addr), .addr_valid(addr_valid),
      .cfg_region(cfg_region), .force_data(force_data),
      .force_en(force_en), .xcvr_en(xcvr_en)
   );

   // {cfg, addr, valid, edges, expected xcvr_en}
   localparam int NV = 9;
   localparam logic [29:0] VEC [NV] = '{
      {4'h5, 16'h5000, 1'b1, 8'd2,  1'b1},  // R6 two edges suffice
      {4'h5, 16'h5ABC, 1'b1, 8'd1,  1'b0},  // R6 one edge is too few
      {4'h5, 16'h5000, 1'b0, 8'd10, 1'b0},  // R5 not valid
      {4'h5, 16'h6000, 1'b1, 8'd10, 1'b0},  // R4 mismatch
      {4'hF, 16'hF000, 1'b1, 8'd2,  1'b1},  // R4 low bits zero
      {4'h0, 16'h0FFF, 1'b1, 8'd2,  1'b1},  // R4 low bits ones
      {4'hB, 16'hA000, 1'b1, 8'd8,  1'b0},  // R4 neighbour value
      {4'h9, 16'h9123, 1'b1, 8'd5,  1'b1},  // R6 long hold
      {4'h3, 16'hB000, 1'b1, 8'd8,  1'b0}   // R4 mismatch
   };

   task automatic check(input logic act, input logic exp, input string req);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
      end
   endtask

   task automatic check8(input logic [7:0] act, input logic [7:0] exp, input string req);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1; addr_valid = 1'b0; addr = 16'h0000;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst = 1'b0;
   endtask

   task automatic step(input logic [15:0] a, input logic v);
      addr = a; addr_valid = v;
      @(posedge clk);
      @(negedge clk);
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin : main
      // R1 reset state
      repeat (2) @(posedge clk);
      @(negedge clk);
      check(force_en, 1'b1, "R1 force_en in reset");
      check(xcvr_en, 1'b0, "R1 xcvr_en in reset");
      check8(force_data, 8'h00, "R1 force_data in reset");

      for (int i = 0; i < NV; i++) begin
         cfg_region = VEC[i][29:26];
         do_reset();
         for (int k = 0; k < int'(VEC[i][8:1]); k++) step(VEC[i][25:10], VEC[i][9]);
         check(xcvr_en, VEC[i][0], $sformatf("R4/R5/R6 vector %0d xcvr_en", i));
         check(force_en, ~VEC[i][0], $sformatf("R3 vector %0d force_en", i));
         if (force_en) check8(force_data, 8'h00, $sformatf("R2 vector %0d data", i));
      end

      // R6 exact latency, edge by edge
      cfg_region = 4'h7;
      do_reset();
      step(16'h7000, 1'b1);
      check(xcvr_en, 1'b0, "R6 after first edge");
      step(16'h7004, 1'b1);
      check(xcvr_en, 1'b1, "R6 after second edge");
      check(force_en, 1'b0, "R3 handoff force_en");

      // R7 single-edge glitches 9 -> B -> A style
      cfg_region = 4'hB;
      do_reset();
      step(16'h9FFF, 1'b1);
      step(16'hBFFF, 1'b1);
      step(16'hA000, 1'b1);
      step(16'hB000, 1'b1);
      step(16'hA002, 1'b1);
      step(16'hB004, 1'b1);
      step(16'h9000, 1'b1);
      check(xcvr_en, 1'b0, "R7 glitches ignored");
      check8(force_data, 8'h00, "R2 data during glitches");

      // R5 match broken by invalid cycle
      cfg_region = 4'h4;
      do_reset();
      step(16'h4000, 1'b1);
      step(16'h4000, 1'b0);
      step(16'h4000, 1'b1);
      step(16'h4000, 1'b0);
      check(xcvr_en, 1'b0, "R5 invalid breaks run");

      // R8 sticky after handoff
      step(16'h4000, 1'b1);
      step(16'h4000, 1'b1);
      check(xcvr_en, 1'b1, "R8 handoff reached");
      cfg_region = 4'h1;
      for (int k = 0; k < 20; k++) step(16'hE000 + 16'(k), k[0]);
      check(xcvr_en, 1'b1, "R8 stays handed off");
      check(force_en, 1'b0, "R8 force stays off");

      // R9 reset after handoff
      do_reset();
      check(xcvr_en, 1'b0, "R9 xcvr off after reset");
      check(force_en, 1'b1, "R9 forcing after reset");
      check8(force_data, 8'h00, "R9 NOP after reset");

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule